// File: doc/BRIEF.md
# Per-CPU Highest-Priority Pending Interrupt Resolver

This block looks over a bank of interrupt sources and, for every CPU interface, picks the most urgent source that is both enabled and pending for that CPU. It reports the winning interrupt ID per CPU and drives one interrupt request line per CPU. The request line is gated twice. The winner must first pass the CPU's priority mask. It must then strictly preempt the priority that the CPU is currently running.

The scan is sequential, with one source index per clock cycle, so that the comparator count stays at one per CPU. A full sweep takes `NUM_SRC` cycles. The reported results are refreshed at the end of every sweep. A `result_valid` flag rises once the first sweep after reset has completed. Any input that is held stable for two full sweeps is fully reflected at the outputs.

Sources below ID 32 have priorities banked per CPU. Sources from 32 up share a single priority value across all CPUs. A smaller priority value means a more urgent interrupt. Running priorities are 9 bits wide, so the idle value 0x100 sits above every 8-bit priority.

Top module: `pend_resolver`

## Requirements
- R1: A source counts as a candidate for CPU c only when both its enable bit and its pending bit are set for c, at flat position c*NUM_SRC+id. Either bit alone has no effect.
- R2: Among the candidates, the one with the numerically lowest priority wins. When priorities are equal, the lowest interrupt ID wins.
- R3: With no candidate, a CPU reports ID 1023 and holds its request line low. The reported ID and request line change only at the last index of a sweep.
- R4: When `dist_en` is low, or that CPU's `cpu_if_en` bit is low, the CPU reports 1023 and its request line is low.
- R5: The winner is reported only if its priority is less than or equal to the CPU's 8-bit mask. Otherwise the CPU reports 1023 and the request line is low.
- R6: The request line is high only when the reported winner's priority is strictly below the CPU's 9-bit running priority. On equality the ID is still reported, but no request is raised.
- R7: A running priority of 0x100 (idle) is preempted by any reported winner, including one at priority 0xFF when the mask is 0xFF.
- R8: The priority of ID i<32 for CPU c is taken from `local_prio[(c*32+i)*8 +: 8]`. The priority of ID i>=32 is taken from `global_prio[(i-32)*8 +: 8]` and is the same for every CPU.
- R9: After reset, every CPU reports 1023 with its request line low and `result_valid` low. `result_valid` rises after the first sweep and stays high. Inputs held stable for 2*NUM_SRC cycles are reflected at the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dist_en | input | 1 | Global distributor enable |
| cpu_if_en | input | NUM_CPU | Per-CPU interface enable |
| prio_mask | input | NUM_CPU*8 | Per-CPU priority mask, CPU c at [c*8 +: 8] |
| run_prio | input | NUM_CPU*9 | Per-CPU running priority, CPU c at [c*9 +: 9], 0x100 = idle |
| src_enable | input | NUM_CPU*NUM_SRC | Enable bit per CPU and source |
| src_pending | input | NUM_CPU*NUM_SRC | Pending bit per CPU and source |
| local_prio | input | NUM_CPU*256 | Banked priorities for IDs 0..31 |
| global_prio | input | GP_W | Shared priorities for IDs 32 and up |
| best_id | output | NUM_CPU*10 | Reported highest-pending ID per CPU, 1023 = none |
| irq_req | output | NUM_CPU | Interrupt request line per CPU |
| result_valid | output | 1 | High once the first complete sweep has finished |

## Verification
The bench targets several corner cases, and each one matches a specific design error:
- Equal-priority ties: a design that used a non-strict compare would report the highest ID instead of the lowest.
- Priority exactly at the mask: an off-by-one in the mask compare would drop a winner that must be reported.
- Running priority equal to the winner's priority: a design with an inclusive compare would raise a request when it must not.
- Idle running priority of 0x100 with a 0xFF winner: an 8-bit running-priority compare would silently truncate and never fire.
- Banked low IDs with different values per CPU: a design that mixed up the banks would pick the wrong winner on one CPU.
- Enable without pending, and pending without enable: a design that used OR would report phantom winners.

The random scenarios concentrate on a few priority values, so that ties and mask boundaries occur often.

// File: rtl/pend_resolve_pkg.sv
package pend_resolve_pkg;
    localparam int          ID_W        = 10;
    localparam int          PRIO_W      = 8;
    localparam int          RUN_W       = 9;
    localparam int          BANKED_IDS  = 32;
    localparam logic [9:0]  SPURIOUS_ID = 10'd1023;
    localparam logic [8:0]  IDLE_PRIO   = 9'h100;

    typedef struct packed {
        logic [RUN_W-1:0] best_prio;
        logic [ID_W-1:0]  best_id;
        logic [ID_W-1:0]  rep_id;
        logic             irq;
    } trk_state_t;
endpackage

// File: rtl/scan_counter.sv
module scan_counter #(
    parameter int NUM_SRC = 64,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [IDX_W-1:0] idx,
    output logic             first,
    output logic             last,
    output logic             valid
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             valid;
    } cnt_t;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SRC - 1);

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q.idx == LAST_IDX) begin
            cnt_d.idx   = '0;
            cnt_d.valid = 1'b1;
        end else begin
            cnt_d.idx = cnt_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign idx   = cnt_q.idx;
    assign first = (cnt_q.idx == '0);
    assign last  = (cnt_q.idx == LAST_IDX);
    assign valid = cnt_q.valid;

    // R9: the index stays in range and steps by one inside a sweep
    a_r9_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        !last |=> (idx == $past(idx) + 1'b1));
    // R9: valid rises only right after the last index of a sweep
    a_r9_valid_after_sweep: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> $past(last));
endmodule

// File: rtl/prio_fetch.sv
module prio_fetch
    import pend_resolve_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_CPU = 2,
    parameter int CPU_IDX = 0,
    localparam int IDX_W  = $clog2(NUM_SRC),
    localparam int LP_W   = NUM_CPU * BANKED_IDS * PRIO_W,
    localparam int GP_W   = (NUM_SRC > BANKED_IDS) ? (NUM_SRC - BANKED_IDS) * PRIO_W : PRIO_W
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [LP_W-1:0]   local_prio,
    input  logic [GP_W-1:0]   global_prio,
    output logic [PRIO_W-1:0] prio
);
    logic [PRIO_W-1:0] local_sel;
    logic [PRIO_W-1:0] global_sel;

    always_comb begin
        local_sel = local_prio[(CPU_IDX * BANKED_IDS + int'(idx[4:0])) * PRIO_W +: PRIO_W];
    end

    generate
        if (NUM_SRC > BANKED_IDS) begin : g_shared
            always_comb begin
                if (int'(idx) >= BANKED_IDS)
                    global_sel = global_prio[(int'(idx) - BANKED_IDS) * PRIO_W +: PRIO_W];
                else
                    global_sel = '1;
            end
        end else begin : g_noshared
            assign global_sel = global_prio[PRIO_W-1:0];
        end
    endgenerate

    assign prio = (int'(idx) < BANKED_IDS) ? local_sel : global_sel;
endmodule

// File: rtl/cpu_tracker.sv
module cpu_tracker
    import pend_resolve_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              first,
    input  logic              last,
    input  logic              cand,
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic [ID_W-1:0]   cand_id,
    input  logic              gate_on,
    input  logic [PRIO_W-1:0] mask,
    input  logic [RUN_W-1:0]  run_prio,
    output logic [ID_W-1:0]   rep_id,
    output logic              irq
);
    trk_state_t st_d, st_q;
    logic [RUN_W-1:0] cur_prio;
    logic [ID_W-1:0]  cur_id;

    always_comb begin
        st_d     = st_q;
        cur_prio = first ? IDLE_PRIO   : st_q.best_prio;
        cur_id   = first ? SPURIOUS_ID : st_q.best_id;
        if (cand && ({1'b0, cand_prio} < cur_prio)) begin
            cur_prio = {1'b0, cand_prio};
            cur_id   = cand_id;
        end
        st_d.best_prio = cur_prio;
        st_d.best_id   = cur_id;
        if (last) begin
            if (!gate_on || (cur_prio > {1'b0, mask})) begin
                st_d.rep_id = SPURIOUS_ID;
                st_d.irq    = 1'b0;
            end else begin
                st_d.rep_id = cur_id;
                st_d.irq    = (cur_prio < run_prio);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.best_prio <= IDLE_PRIO;
            st_q.best_id   <= SPURIOUS_ID;
            st_q.rep_id    <= SPURIOUS_ID;
            st_q.irq       <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rep_id = st_q.rep_id;
    assign irq    = st_q.irq;

    // R4: a disabled gate at commit yields spurious and no request
    a_r4_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !gate_on) |=> (rep_id == SPURIOUS_ID && !irq));
    // R6: a request always comes with a reported winner
    a_r6_irq_has_winner: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rep_id != SPURIOUS_ID));
    // R3: outputs move only at the end of a sweep
    a_r3_hold_mid_sweep: assert property (@(posedge clk) disable iff (!rst_n)
        !last |=> ($stable(rep_id) && $stable(irq)));
endmodule

// File: rtl/pend_resolver.sv
module pend_resolver
    import pend_resolve_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_CPU = 2,
    localparam int IDX_W  = $clog2(NUM_SRC),
    localparam int LP_W   = NUM_CPU * BANKED_IDS * PRIO_W,
    localparam int GP_W   = (NUM_SRC > BANKED_IDS) ? (NUM_SRC - BANKED_IDS) * PRIO_W : PRIO_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       dist_en,
    input  logic [NUM_CPU-1:0]         cpu_if_en,
    input  logic [NUM_CPU*PRIO_W-1:0]  prio_mask,
    input  logic [NUM_CPU*RUN_W-1:0]   run_prio,
    input  logic [NUM_CPU*NUM_SRC-1:0] src_enable,
    input  logic [NUM_CPU*NUM_SRC-1:0] src_pending,
    input  logic [LP_W-1:0]            local_prio,
    input  logic [GP_W-1:0]            global_prio,
    output logic [NUM_CPU*ID_W-1:0]    best_id,
    output logic [NUM_CPU-1:0]         irq_req,
    output logic                       result_valid
);
    logic [IDX_W-1:0] idx;
    logic             first;
    logic             last;

    scan_counter #(.NUM_SRC(NUM_SRC)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .idx   (idx),
        .first (first),
        .last  (last),
        .valid (result_valid)
    );

    generate
        for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
            logic [PRIO_W-1:0] prio;
            logic              cand;

            prio_fetch #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .CPU_IDX(c)) u_fetch (
                .idx         (idx),
                .local_prio  (local_prio),
                .global_prio (global_prio),
                .prio        (prio)
            );

            assign cand = src_enable[c*NUM_SRC + int'(idx)] & src_pending[c*NUM_SRC + int'(idx)];

            cpu_tracker u_trk (
                .clk       (clk),
                .rst_n     (rst_n),
                .first     (first),
                .last      (last),
                .cand      (cand),
                .cand_prio (prio),
                .cand_id   (ID_W'(idx)),
                .gate_on   (dist_en & cpu_if_en[c]),
                .mask      (prio_mask[c*PRIO_W +: PRIO_W]),
                .run_prio  (run_prio[c*RUN_W +: RUN_W]),
                .rep_id    (best_id[c*ID_W +: ID_W]),
                .irq       (irq_req[c])
            );
        end
    endgenerate
endmodule

// File: tb/tb_pend_resolver.sv
module tb_pend_resolver;
    localparam int NSRC = 64;
    localparam int NCPU = 2;
    localparam int LPW  = NCPU * 32 * 8;
    localparam int GPW  = (NSRC - 32) * 8;

    logic clk = 0;
    logic rst_n = 0;
    logic dist_en = 0;
    logic [NCPU-1:0]      cpu_if_en = '0;
    logic [NCPU*8-1:0]    prio_mask = '0;
    logic [NCPU*9-1:0]    run_prio  = '0;
    logic [NCPU*NSRC-1:0] src_enable  = '0;
    logic [NCPU*NSRC-1:0] src_pending = '0;
    logic [LPW-1:0]       local_prio  = '0;
    logic [GPW-1:0]       global_prio = '0;
    logic [NCPU*10-1:0]   best_id;
    logic [NCPU-1:0]      irq_req;
    logic                 result_valid;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    pend_resolver #(.NUM_SRC(NSRC), .NUM_CPU(NCPU)) dut (
        .clk(clk), .rst_n(rst_n), .dist_en(dist_en), .cpu_if_en(cpu_if_en),
        .prio_mask(prio_mask), .run_prio(run_prio), .src_enable(src_enable),
        .src_pending(src_pending), .local_prio(local_prio), .global_prio(global_prio),
        .best_id(best_id), .irq_req(irq_req), .result_valid(result_valid)
    );

    function automatic int src_prio(input int c, input int id);
        if (id < 32) return int'(local_prio[(c*32+id)*8 +: 8]);
        return int'(global_prio[(id-32)*8 +: 8]);
    endfunction

    function automatic logic [10:0] model(input int c);
        int best = 256;
        int bid  = 1023;
        for (int id = 0; id < NSRC; id++) begin
            if (src_enable[c*NSRC+id] && src_pending[c*NSRC+id] && src_prio(c, id) < best) begin
                best = src_prio(c, id);
                bid  = id;
            end
        end
        if (!dist_en || !cpu_if_en[c]) return {1'b0, 10'd1023};
        if (best > int'(prio_mask[c*8 +: 8])) return {1'b0, 10'd1023};
        return {(best < int'(run_prio[c*9 +: 9])), 10'(bid)};
    endfunction

    task automatic settle();
        repeat (2*NSRC + 2) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_cpu(input string tag, input int c);
        logic [10:0] exp = model(c);
        logic [10:0] act = {irq_req[c], best_id[c*10 +: 10]};
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s cpu%0d: actual irq=%0b id=%0d expected irq=%0b id=%0d",
                     tag, c, act[10], act[9:0], exp[10], exp[9:0]);
        end
    endtask

    task automatic check_all(input string tag);
        for (int c = 0; c < NCPU; c++) check_cpu(tag, c);
    endtask

    task automatic check_val(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic base_cfg();
        dist_en = 1; cpu_if_en = '1;
        prio_mask = {NCPU{8'hFF}};
        run_prio  = {NCPU{9'h100}};
        src_enable = '0; src_pending = '0;
        for (int i = 0; i < NCPU*32; i++) local_prio[i*8 +: 8] = 8'h80;
        for (int i = 0; i < NSRC-32; i++) global_prio[i*8 +: 8] = 8'h80;
    endtask

    task automatic setsrc(input int c, input int id, input int p);
        src_enable[c*NSRC+id] = 1; src_pending[c*NSRC+id] = 1;
        if (id < 32) local_prio[(c*32+id)*8 +: 8] = 8'(p);
        else global_prio[(id-32)*8 +: 8] = 8'(p);
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R9 reset state
        check_val("R9 valid after reset", int'(result_valid), 0);
        check_val("R9 id after reset", int'(best_id[9:0]), 1023);
        check_val("R9 irq after reset", int'(irq_req), 0);

        base_cfg();
        settle();
        check_val("R9 valid after sweep", int'(result_valid), 1);
        check_all("R3 no candidate");

        // R1 enable without pending and pending without enable
        src_enable[5] = 1; src_pending[NSRC+7] = 1;
        settle();
        check_all("R1 half-set bits");

        // R2 tie: IDs 40 and 45 share priority; 40 must win
        base_cfg(); setsrc(0, 45, 16); setsrc(0, 40, 16); setsrc(0, 50, 32);
        settle();
        check_all("R2 tie lowest id");
        check_val("R2 tie id", int'(best_id[9:0]), 40);

        // R5 priority equal to mask is reported; above it is not
        prio_mask[7:0] = 8'd16;
        settle();
        check_all("R5 mask equal");
        prio_mask[7:0] = 8'd15;
        settle();
        check_all("R5 mask below");
        check_val("R5 masked id", int'(best_id[9:0]), 1023);

        // R6 running priority equal: reported but no request
        prio_mask[7:0] = 8'hFF; run_prio[8:0] = 9'd16;
        settle();
        check_all("R6 run equal");
        check_val("R6 no irq", int'(irq_req[0]), 0);
        run_prio[8:0] = 9'd17;
        settle();
        check_val("R6 irq strict", int'(irq_req[0]), 1);

        // R7 idle running priority preempted by 0xFF
        base_cfg(); setsrc(1, 60, 8'hFF);
        settle();
        check_all("R7 idle preempt");
        check_val("R7 irq", int'(irq_req[1]), 1);

        // R4 gating
        dist_en = 0;
        settle();
        check_all("R4 dist off");
        dist_en = 1; cpu_if_en[1] = 0;
        settle();
        check_all("R4 cpu off");

        // R8 banked low IDs differ per CPU
        base_cfg();
        setsrc(0, 3, 10); setsrc(0, 9, 50);
        setsrc(1, 3, 90); setsrc(1, 9, 20);
        settle();
        check_all("R8 banked");
        check_val("R8 cpu1 id", int'(best_id[19:10]), 9);

        // random scenarios, R1..R8 together
        for (int t = 0; t < 60; t++) begin
            base_cfg();
            dist_en   = ($urandom % 8) != 0;
            cpu_if_en = NCPU'($urandom | ((($urandom % 4) != 0) ? 32'h3 : 32'h0));
            for (int c = 0; c < NCPU; c++) begin
                prio_mask[c*8 +: 8] = 8'(($urandom % 4) * 64 + ($urandom % 2) * 63);
                run_prio[c*9 +: 9]  = (($urandom % 3) == 0) ? 9'h100 : 9'($urandom % 256);
            end
            for (int i = 0; i < NCPU*NSRC; i++) begin
                src_enable[i]  = ($urandom % 3) == 0;
                src_pending[i] = ($urandom % 3) == 0;
            end
            for (int i = 0; i < NCPU*32; i++) local_prio[i*8 +: 8] = 8'(($urandom % 8) * 32);
            for (int i = 0; i < NSRC-32; i++) global_prio[i*8 +: 8] = 8'(($urandom % 8) * 32);
            settle();
            check_all("R2 random");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule